// File: doc/BRIEF.md
# Remote two-wire transaction sequencer

This block runs one remote two-wire access at a time on behalf of a host. The host fills a sixteen-entry byte buffer, a target byte (7-bit device address plus a direction bit), a length byte and a configuration byte through a simple register port. It then writes the start bit. The engine sends a header byte, the sub-address bytes and, for a write, the payload bytes as a valid/ready byte stream toward a downstream link master. For a read, it stores the returned bytes back into the buffer. Sub-address and payload share the one buffer, and both lengths are held as count minus one.

Completion is reported in one of two ways, chosen by a configuration bit. In the first, a stretch-hold output stays high for the whole transaction, so the host's own bus access can be held off until the work is done. In the second, a level interrupt is raised and stays high until the host clears it. A target address equal to the remote bridge's own address is flagged, so that the access can be routed to the bridge's internal registers and not to the slaves behind it.

Stream rules: a byte is transferred on a clock where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the byte and the valid stay unchanged. The downstream side may hold `tx_ready` low for any number of cycles. Read-back bytes carry no back-pressure: each cycle with `rb_valid` high in the receive phase delivers one byte.

Top module: `rmt_xfer_seq`

## Requirements
- R1: After reset, `tx_valid`, `stretch_hold` and `irq` are low, and all registers and the buffer read as zero.
- R2: Register map, with N = NBYTE (16 by default). Buffer entry k is at address k, for k from 0 to N-1. Target is at N: bit 0 is the direction (1 = read) and bits [7:1] are the device address. Length is at N+1: bits [6:4] hold the sub-address count minus one and bits [3:0] hold the data count minus one. Configuration is at N+2: bit 0 is stretch enable, bits [3:2] are the read lane and bits [5:4] are the write lane. Start is at N+3: writing bit 0 as 1 starts a transaction, and the register reads 0. Status is at N+4: bit 0 is irq, bit 1 is error, bit 2 is busy, and writing 1 to bit 0 or bit 1 clears that flag. Unused addresses read 0.
- R3: A started transaction first sends the target byte unchanged. It then sends the sub-address bytes from buffer entries 0 upward.
- R4: For a write, the data bytes follow from the next buffer entries. `tx_last` is high on the final byte of the stream only.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R6: For a read, `tx_last` marks the last sub-address byte. The next data-count `rb_valid` bytes are then written into buffer entries 0, 1, 2 and so on, and `rb_valid` has no effect at any other time.
- R7: When stretch enable is 1, `stretch_hold` is high from the cycle after start until the transaction ends, and no interrupt is raised.
- R8: When stretch enable is 0, the end of a transaction sets `irq`. It stays set until status bit 0 is written as 1. If a set and a clear fall on the same cycle, the set wins.
- R9: A start written while a transaction is in progress is ignored, and it sets the error flag.
- R10: A write start whose sub-address field plus data field exceeds N-2 is rejected with no stream, and it sets the error flag.
- R11: `lane_sel` shows the read lane when target bit 0 is 1, and the write lane otherwise.
- R12: `to_bridge` is high exactly when target bits [7:1] equal `bridge_addr`.
- R13: While busy, host writes to the buffer, target, length and configuration have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | AW | Host register address (write and read) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Register view at `reg_addr` |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the outgoing stream |
| rb_valid | input | 1 | Read-back byte strobe |
| rb_data | input | 8 | Read-back byte |
| bridge_addr | input | 7 | Remote bridge's own device address |
| to_bridge | output | 1 | Target is the bridge itself |
| lane_sel | output | 2 | Lane chosen for the current direction |
| stretch_hold | output | 1 | Hold request for the host's bus access |
| irq | output | 1 | Completion interrupt, level-held |

## Verification
The bench builds the block with its default of sixteen buffer entries, which puts the control registers at 16 to 20. It uses that size because it reaches both edges of the shared buffer. A write of eight sub-address bytes plus eight data bytes fills every entry, a read of sixteen bytes overwrites all of them, and a length pair one beyond the limit shows the rejection. The downstream ready input stalls one cycle in four, and read-back bytes arrive on an irregular pattern both inside and outside the receive phase.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_SUB,
    ST_DAT,
    ST_RCV
  } rxs_state_e;

  localparam int SUB_W = 3;
endpackage

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter int NBYTE = 16,
  parameter int AW    = 5,
  parameter int IW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [AW-1:0]        host_addr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_view,
  input  logic                 busy,
  input  logic                 rb_we,
  input  logic [IW-1:0]        eng_idx,
  input  logic [7:0]           rb_data,
  output logic [7:0]           buf_byte,
  output logic [7:0]           tgt,
  output logic [SUB_W-1:0]     sub_m1,
  output logic [IW-1:0]        dat_m1,
  output logic [5:0]           cfg
);
  localparam int LW = IW + SUB_W;
  localparam logic [AW-1:0] A_TGT = AW'(NBYTE);
  localparam logic [AW-1:0] A_LEN = AW'(NBYTE + 1);
  localparam logic [AW-1:0] A_CFG = AW'(NBYTE + 2);

  logic [7:0]    buf_q [NBYTE];
  logic [7:0]    tgt_q;
  logic [LW-1:0] len_q;
  logic [5:0]    cfg_q;
  logic          host_ok;

  assign host_ok = host_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) buf_q[i] <= '0;
      tgt_q <= '0;
      len_q <= '0;
      cfg_q <= '0;
    end else begin
      if (host_ok && host_addr < A_TGT) buf_q[host_addr[IW-1:0]] <= host_wdata;
      else if (rb_we)                   buf_q[eng_idx] <= rb_data;
      if (host_ok && host_addr == A_TGT) tgt_q <= host_wdata;
      if (host_ok && host_addr == A_LEN) len_q <= host_wdata[LW-1:0];
      if (host_ok && host_addr == A_CFG) cfg_q <= host_wdata[5:0];
    end
  end

  always_comb begin
    host_view = '0;
    if (host_addr < A_TGT)       host_view = buf_q[host_addr[IW-1:0]];
    else if (host_addr == A_TGT) host_view = tgt_q;
    else if (host_addr == A_LEN) host_view = 8'(len_q);
    else if (host_addr == A_CFG) host_view = {2'b00, cfg_q};
  end

  assign buf_byte = buf_q[eng_idx];
  assign tgt      = tgt_q;
  assign sub_m1   = len_q[LW-1:IW];
  assign dat_m1   = len_q[IW-1:0];
  assign cfg      = cfg_q;

  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rb_we |=> $stable(buf_q[0]) && $stable(tgt_q)); // R13
endmodule

// File: rtl/rxs_engine.sv
module rxs_engine
  import rxs_pkg::*;
#(
  parameter int NBYTE = 16,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             clr_irq,
  input  logic             clr_err,
  input  logic [7:0]       tgt,
  input  logic [SUB_W-1:0] sub_m1,
  input  logic [IW-1:0]    dat_m1,
  input  logic             stretch_en,
  input  logic             out_ready,
  input  logic             rb_valid,
  input  logic [7:0]       buf_byte,
  output logic             busy,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             rb_we,
  output logic [IW-1:0]    idx,
  output logic             irq,
  output logic             err,
  output logic             stretch_hold
);
  localparam int SUMW = IW + 1;
  localparam logic [SUMW-1:0] SUM_MAX = SUMW'(NBYTE - 2);

  rxs_state_e    st_q;
  logic [IW-1:0] idx_q, cnt_q;
  logic [SUMW-1:0] len_sum;
  logic is_rd, legal, accept, fire, done;

  assign is_rd   = tgt[0];
  assign len_sum = SUMW'(sub_m1) + SUMW'(dat_m1);
  assign legal   = is_rd || (len_sum <= SUM_MAX);
  assign accept  = start_req && (st_q == ST_IDLE) && legal;

  assign busy      = (st_q != ST_IDLE);
  assign out_valid = (st_q == ST_HDR) || (st_q == ST_SUB) || (st_q == ST_DAT);
  assign out_data  = (st_q == ST_HDR) ? tgt : buf_byte;
  assign out_last  = (cnt_q == '0) && (((st_q == ST_SUB) && is_rd) || (st_q == ST_DAT));
  assign fire      = out_valid && out_ready;
  assign rb_we     = (st_q == ST_RCV) && rb_valid;
  assign done      = (cnt_q == '0) && (((st_q == ST_DAT) && fire) || rb_we);
  assign idx       = idx_q;
  assign stretch_hold = busy && stretch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      irq   <= 1'b0;
      err   <= 1'b0;
    end else begin
      irq <= (irq && !clr_irq) || (done && !stretch_en);
      err <= (err && !clr_err) || (start_req && !accept);
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_HDR;
          idx_q <= '0;
        end
        ST_HDR: if (fire) begin
          st_q  <= ST_SUB;
          cnt_q <= IW'(sub_m1);
        end
        ST_SUB: if (fire) begin
          if (cnt_q == '0) begin
            cnt_q <= dat_m1;
            if (is_rd) begin
              st_q  <= ST_RCV;
              idx_q <= '0;
            end else begin
              st_q  <= ST_DAT;
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DAT: if (fire) begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) st_q <= ST_IDLE;
        end
        ST_RCV: if (rb_valid) begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_last |=> !out_valid); // R4
  AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    start_req && busy |=> err); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq); // R8
endmodule

// File: rtl/rmt_xfer_seq.sv
module rmt_xfer_seq
  import rxs_pkg::*;
#(
  parameter int NBYTE = 16,
  parameter int AW    = $clog2(NBYTE + 5)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          rb_valid,
  input  logic [7:0]    rb_data,
  input  logic [6:0]    bridge_addr,
  output logic          to_bridge,
  output logic [1:0]    lane_sel,
  output logic          stretch_hold,
  output logic          irq
);
  localparam int IW = $clog2(NBYTE);
  localparam logic [AW-1:0] A_CMD = AW'(NBYTE + 3);
  localparam logic [AW-1:0] A_STS = AW'(NBYTE + 4);

  logic             busy, err, rb_we;
  logic [IW-1:0]    eng_idx;
  logic [7:0]       buf_byte, tgt, view;
  logic [SUB_W-1:0] sub_m1;
  logic [IW-1:0]    dat_m1;
  logic [5:0]       cfg;
  logic             start_req, clr_irq, clr_err;

  assign start_req = reg_we && (reg_addr == A_CMD) && reg_wdata[0];
  assign clr_irq   = reg_we && (reg_addr == A_STS) && reg_wdata[0];
  assign clr_err   = reg_we && (reg_addr == A_STS) && reg_wdata[1];

  rxs_regs #(.NBYTE(NBYTE), .AW(AW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(reg_we), .host_addr(reg_addr), .host_wdata(reg_wdata), .host_view(view),
    .busy(busy), .rb_we(rb_we), .eng_idx(eng_idx), .rb_data(rb_data),
    .buf_byte(buf_byte), .tgt(tgt), .sub_m1(sub_m1), .dat_m1(dat_m1), .cfg(cfg)
  );

  rxs_engine #(.NBYTE(NBYTE), .IW(IW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .clr_irq(clr_irq), .clr_err(clr_err),
    .tgt(tgt), .sub_m1(sub_m1), .dat_m1(dat_m1), .stretch_en(cfg[0]),
    .out_ready(tx_ready), .rb_valid(rb_valid), .buf_byte(buf_byte),
    .busy(busy), .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last),
    .rb_we(rb_we), .idx(eng_idx), .irq(irq), .err(err), .stretch_hold(stretch_hold)
  );

  assign reg_rdata = (reg_addr == A_STS) ? {5'b0, busy, err, irq} : view;
  assign lane_sel  = tgt[0] ? cfg[3:2] : cfg[5:4];
  assign to_bridge = (tgt[7:1] == bridge_addr);

  AST_STRETCH_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_hold && !irq |=> !irq); // R7
endmodule

// File: tb/rmt_xfer_seq_bench.sv
module rmt_xfer_seq_bench;
  localparam int CLK_P = 10;
  localparam logic [6:0] BR_ADDR = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] scan_a = '0, w_a = '0;
  logic [7:0] w_d = '0;
  logic we = 1'b0;
  logic [4:0] reg_addr;
  logic [7:0] reg_rdata, tx_data, rb_data = '0;
  logic tx_valid, tx_last, tx_ready = 1'b0, rb_valid = 1'b0;
  logic to_bridge, stretch_hold, irq;
  logic [1:0] lane_sel;
  int vecs = 0, miss = 0, cyc = 0;
  bit cmp_en = 0, fin_f = 0;

  always #(CLK_P/2) clk = ~clk;
  assign reg_addr = we ? w_a : scan_a;

  rmt_xfer_seq u_rmt_xfer_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(reg_addr), .reg_wdata(w_d),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .rb_valid(rb_valid), .rb_data(rb_data), .bridge_addr(BR_ADDR),
    .to_bridge(to_bridge), .lane_sel(lane_sel), .stretch_hold(stretch_hold), .irq(irq)
  );

  // behavioural reference model
  logic [7:0] m_buf [16];
  logic [7:0] m_tgt = '0, m_len = '0, m_cfg = '0;
  logic [7:0] m_q [$];
  bit m_irq = 0, m_err = 0;
  int m_rcv = 0, m_ridx = 0;

  function automatic bit busy_f();
    return (m_q.size() > 0) || (m_rcv > 0);
  endfunction

  function automatic logic [7:0] m_view(int a);
    if (a < 16) return m_buf[a];
    case (a)
      16: return m_tgt;
      17: return m_len;
      18: return m_cfg;
      20: return {5'b0, busy_f(), m_err, m_irq};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit b, fin;
    int s, d;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_buf[i] = '0;
      m_tgt = '0; m_len = '0; m_cfg = '0; m_q.delete();
      m_irq = 0; m_err = 0; m_rcv = 0; m_ridx = 0;
    end else begin
      b = busy_f(); fin = 0;
      if (we && w_a == 20) begin
        if (w_d[0]) m_irq = 0;
        if (w_d[1]) m_err = 0;
      end
      if (m_q.size() > 0) begin
        if (tx_ready) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_tgt[0]) begin m_rcv = m_len[3:0] + 1; m_ridx = 0; end
            else fin = 1;
          end
        end
      end else if (m_rcv > 0 && rb_valid) begin
        m_buf[m_ridx] = rb_data; m_ridx++; m_rcv--;
        if (m_rcv == 0) fin = 1;
      end
      if (fin && !m_cfg[0]) m_irq = 1;
      if (we && w_a == 19 && w_d[0]) begin
        s = m_len[6:4]; d = m_len[3:0];
        if (b) m_err = 1;
        else if (!m_tgt[0] && s + d > 14) m_err = 1;
        else begin
          m_q.push_back(m_tgt);
          for (int i = 0; i <= s; i++) m_q.push_back(m_buf[i]);
          if (!m_tgt[0]) for (int i = s + 1; i <= s + d + 1; i++) m_q.push_back(m_buf[i]);
        end
      end
      if (we && !b) begin
        if (w_a < 16) m_buf[w_a] = w_d;
        else if (w_a == 16) m_tgt = w_d;
        else if (w_a == 17) m_len = w_d & 8'h7F;
        else if (w_a == 18) m_cfg = w_d & 8'h3F;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #(CLK_P/4);
    if (cmp_en && !fin_f) begin
      chk("R3 R5 tx_valid", int'(tx_valid), int'(m_q.size() > 0));
      if (m_q.size() > 0) begin
        chk("R3 R4 tx_data", int'(tx_data), int'(m_q[0]));
        chk("R4 R6 tx_last", int'(tx_last), int'(m_q.size() == 1));
      end
      chk("R7 stretch_hold", int'(stretch_hold), int'(busy_f() && m_cfg[0]));
      chk("R8 irq", int'(irq), int'(m_irq));
      chk("R2 R6 R9 R10 R13 reg_rdata", int'(reg_rdata), int'(m_view(int'(reg_addr))));
      chk("R11 lane_sel", int'(lane_sel), int'(m_tgt[0] ? m_cfg[3:2] : m_cfg[5:4]));
      chk("R12 to_bridge", int'(to_bridge), int'(m_tgt[7:1] == BR_ADDR));
    end
  end

  // stimulus patterns for ready, read-back and register scan
  always @(negedge clk) begin
    cyc++;
    tx_ready <= (cyc % 4) != 3;
    rb_valid <= cyc[0] ^ cyc[2];
    rb_data  <= 8'(cyc * 7 + 3);
    scan_a   <= scan_a + 1'b1;
  end

  task automatic finish_run();
    fin_f = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !fin_f) begin
      miss++;
      $display("FAIL watchdog all requirements act=running exp=idle");
      finish_run();
    end
  end

  task automatic hw(int a, int d);
    @(negedge clk);
    we = 1'b1; w_a = 5'(a); w_d = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_f()) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 stretch_hold", int'(stretch_hold), 0);
    chk("R1 irq", int'(irq), 0);
    for (int i = 0; i < 16; i++) hw(i, 16 + i * 3);
    // R3 R4 R7 R11: write, two sub bytes, four data bytes, stretch mode
    hw(16, {7'h21, 1'b0}); hw(17, 8'h13); hw(18, 8'h25); hw(19, 1);
    wait_idle();
    // R8 R13: full-buffer write in irq mode, writes while busy ignored
    hw(18, 8'h24); hw(17, 8'h77); hw(19, 1);
    hw(3, 8'hEE); hw(16, 8'h00); hw(18, 8'h25);
    wait_idle();
    hw(20, 1);
    // R6 R12: read from the bridge itself, five bytes back
    hw(16, {BR_ADDR, 1'b1}); hw(17, 8'h04); hw(19, 1);
    wait_idle();
    hw(20, 1);
    // R9: second start while busy
    hw(16, 8'h42); hw(17, 8'h0E); hw(19, 1); hw(19, 1);
    wait_idle();
    hw(20, 3);
    // R10: sub field 7 plus data field 8 is one beyond the limit
    hw(17, 8'h78); hw(19, 1);
    repeat (4) @(negedge clk);
    chk("R10 no stream", int'(tx_valid), 0);
    hw(20, 2);
    // R6: read with eight sub bytes, sixteen bytes back
    hw(16, 8'h43); hw(17, 8'h7F); hw(19, 1);
    wait_idle();
    hw(20, 1);
    repeat (25) @(negedge clk);
    finish_run();
  end
endmodule